// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a 32-bit down-counting interrupt timer for the local interrupt controller of a processor core. Software programs four word registers through a simple register port: an entry word that holds the interrupt vector, the mask and the run mode; a start value; a live count that can only be read; and a divide setting. A power-of-two prescaler, clocked by an external tick enable, sets how often the live count steps down by one.

When the live count steps from one to zero, the timer ends its run. In repeating mode the live count reloads from the start value and keeps going. In single-shot mode it stays at zero and the timer goes idle. When the entry is unmasked, each expiry raises a one-cycle request that carries the entry's 8-bit vector. The request is a fixed-mode, edge-style request. Writing the start value starts or restarts a run, and writing zero stops the timer.

Top module: `irq_countdown_timer`

## Requirements
- R1: After a synchronous active-low reset, the following values hold:
  - The entry word (offset 0x320) reads 0x0001_0000, which means masked, single-shot, vector 0.
  - The start value (0x380), the live count (0x390) and the divide setting (0x3E0) all read 0.
  - `irq_pulse` is low.
- R2: A read of any of the four offsets returns the full 32-bit word last stored there, including bits that the timer does not use. Any other offset reads 0.
- R3: A write to the start value (0x380) stores the word and also loads it into the live count at the same clock edge. It also restarts the prescaler, so the first step comes a full divide period after the write.
- R4: Writes to the live count offset (0x390) have no effect on the count.
- R5: The divide index is {div[3], div[1:0]}. Index 3'b111 gives shift 0; any other index gives shift index+1. The live count drops by one every 2^shift cycles in which `tick_en` is high. A start value N therefore expires N*2^shift enabled cycles after the write edge, and `irq_pulse` is high in the cycle that follows that edge.
- R6: While `tick_en` is low, the live count does not change.
- R7: The run mode is the entry field bits 18:17. When this field is not 2'b01 (single-shot), an expiry leaves the live count at 0 and produces exactly one request.
- R8: When the run mode field is 2'b01 (repeating), each expiry reloads the live count from the start value. Requests then follow every N*2^shift enabled cycles.
- R9: A request lasts one cycle and carries `irq_vector` = entry bits 7:0 at expiry. It is raised only if mask bit 16 is clear. A masked expiry still reloads or stops the count.
- R10: A live count of 0 is idle. No further requests come until a nonzero start value is written, and writing 0 to the start value stops a running timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick enable; the prescaler counts only when this is high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the latest request, valid with `irq_pulse` |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is low at the first clock edge.
- `reg_addr` and `reg_wdata` are stable whenever `reg_wr_en` is high at an edge.

The bench follows these rules as well:
- It holds reset for several cycles from time zero.
- It changes every input only on the falling clock edge.
- It raises the write strobe for exactly one rising edge per access.
- It keeps `tick_en` high except in the freeze test, so that each expected request cycle follows directly from the write edge and the divide setting.

// File: rtl/itmr_pkg.sv
// Shared constants and helpers for the countdown interrupt timer.
// Assumes 32-bit registers at fixed 12-bit byte offsets.
package itmr_pkg;
    localparam int REG_AW   = 12;
    localparam int REG_DW   = 32;
    localparam int SHIFT_W  = 3;

    localparam logic [REG_AW-1:0] OFS_ENTRY = 12'h320;
    localparam logic [REG_AW-1:0] OFS_START = 12'h380;
    localparam logic [REG_AW-1:0] OFS_LIVE  = 12'h390;
    localparam logic [REG_AW-1:0] OFS_DIV   = 12'h3E0;

    localparam int MASK_BIT  = 16;
    localparam int MODE_LSB  = 17;
    localparam logic [1:0] MODE_REPEAT = 2'b01;
    localparam logic [REG_DW-1:0] ENTRY_RST = 32'h0001_0000;

    // Map a divide word to a prescaler shift: index {d[3],d[1:0]}, 7 -> 0, else +1.
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [REG_DW-1:0] cfg);
        logic [SHIFT_W-1:0] idx;
        idx = {cfg[3], cfg[1:0]};
        return (idx == 3'b111) ? '0 : idx + 1'b1;
    endfunction
endpackage

// File: rtl/itmr_regs.sv
// Register file of the countdown timer: entry word, start value, divide
// setting, and the combinational read mux. Assumes a one-cycle write strobe.
// The live count is owned by the core and only routed here for reads.
module itmr_regs
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic [REG_DW-1:0] live_cnt,
    output logic [REG_DW-1:0] rdata,
    output logic [REG_DW-1:0] start_val,
    output logic [7:0]        ent_vector,
    output logic              ent_masked,
    output logic [1:0]        ent_mode,
    output logic [SHIFT_W-1:0] div_shift
);
    logic [REG_DW-1:0] entry_q;
    logic [REG_DW-1:0] start_q;
    logic [REG_DW-1:0] div_q;

    // Store software-writable words; the live count offset is not writable here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= ENTRY_RST;
            start_q <= '0;
            div_q   <= '0;
        end else if (wr_en) begin
            if (addr == OFS_ENTRY) entry_q <= wdata;
            if (addr == OFS_START) start_q <= wdata;
            if (addr == OFS_DIV)   div_q   <= wdata;
        end
    end

    // Return the full stored word for a mapped offset, zero otherwise.
    always_comb begin
        unique case (addr)
            OFS_ENTRY: rdata = entry_q;
            OFS_START: rdata = start_q;
            OFS_LIVE:  rdata = live_cnt;
            OFS_DIV:   rdata = div_q;
            default:   rdata = '0;
        endcase
    end

    assign start_val  = start_q;
    assign ent_vector = entry_q[7:0];
    assign ent_masked = entry_q[MASK_BIT];
    assign ent_mode   = entry_q[MODE_LSB+1:MODE_LSB];
    assign div_shift  = div_to_shift(div_q);
endmodule

// File: rtl/itmr_prescaler.sv
// Power-of-two prescaler: emits one step every 2^shift enabled ticks.
// Assumes shift changes only between runs; restart clears the phase.
module itmr_prescaler #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               step
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;

    // Terminal phase value for the selected shift.
    always_comb begin
        span  = {{PRE_W{1'b0}}, 1'b1} << shift;
        limit = PRE_W'(span - 1'b1);
    end

    assign step = tick_en && (pre_q == limit);

    // Advance the phase on enabled ticks, wrap at the limit, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || step) begin
            pre_q <= '0;
        end else if (tick_en) begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/itmr_core.sv
// Down counter and request generator. Expiry is the step from 1 to 0;
// a load in the same cycle wins over a step. Assumes one step per cycle at most.
module itmr_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             repeat_mode,
    input  logic [CNT_W-1:0] start_val,
    input  logic             masked,
    input  logic [7:0]       vector_in,
    output logic [CNT_W-1:0] live_cnt,
    output logic             irq_pulse,
    output logic [7:0]       irq_vector
);
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    assign expire   = step && !load && (cnt_q == CNT_W'(1));
    assign live_cnt = cnt_q;

    // Load, count down, reload or stop at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && cnt_q != '0) begin
            if (expire) cnt_q <= repeat_mode ? start_val : '0;
            else        cnt_q <= cnt_q - 1'b1;
        end
    end

    // Raise a one-cycle request with the vector when expiry is unmasked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_pulse <= expire && !masked;
            if (expire && !masked) irq_vector <= vector_in;
        end
    end
endmodule

// File: rtl/irq_countdown_timer.sv
// Top of the countdown interrupt timer: register file, prescaler, core.
// Assumes a single-cycle write strobe and a combinational read port.
module irq_countdown_timer
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq_pulse,
    output logic [7:0]        irq_vector
);
    logic [REG_DW-1:0]  cur_cnt;
    logic [REG_DW-1:0]  start_val;
    logic [7:0]         ent_vector;
    logic               ent_masked;
    logic [1:0]         ent_mode;
    logic [SHIFT_W-1:0] div_shift;
    logic               load;
    logic               step;

    assign load = reg_wr_en && (reg_addr == OFS_START);

    itmr_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .live_cnt   (cur_cnt),
        .rdata      (reg_rdata),
        .start_val  (start_val),
        .ent_vector (ent_vector),
        .ent_masked (ent_masked),
        .ent_mode   (ent_mode),
        .div_shift  (div_shift)
    );

    itmr_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .restart (load),
        .shift   (div_shift),
        .step    (step)
    );

    itmr_core #(.CNT_W(REG_DW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_val    (reg_wdata),
        .step        (step),
        .repeat_mode (ent_mode == MODE_REPEAT),
        .start_val   (start_val),
        .masked      (ent_masked),
        .vector_in   (ent_vector),
        .live_cnt    (cur_cnt),
        .irq_pulse   (irq_pulse),
        .irq_vector  (irq_vector)
    );
endmodule

// File: rtl/itmr_checker.sv
// Property checker for the countdown timer, bound to the top module.
// Assumes reset is low at the first clock edge.
module itmr_checker
    import itmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              load,
    input logic [REG_DW-1:0] reg_wdata,
    input logic              step,
    input logic [REG_DW-1:0] cur_cnt,
    input logic [7:0]        ent_vector,
    input logic              ent_masked,
    input logic [1:0]        ent_mode,
    input logic              irq_pulse,
    input logic [7:0]        irq_vector
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (ent_masked && cur_cnt == '0 && !irq_pulse)); // R1

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_cnt == $past(reg_wdata)); // R3

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cur_cnt)); // R4

    AST_FREEZE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |-> !step); // R6

    AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(ent_mode) != MODE_REPEAT) |-> cur_cnt == '0); // R7

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(ent_masked)); // R9

    AST_VECTOR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_vector == $past(ent_vector)); // R9

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cnt == '0 && !load) |=> (cur_cnt == '0 && !irq_pulse)); // R10
endmodule

bind irq_countdown_timer itmr_checker u_chk (.*);

// File: tb/irq_countdown_timer_tb_top.sv
// Scoreboard bench: tasks schedule expected requests, a monitor matches them.
module irq_countdown_timer_tb_top;
    localparam logic [11:0] A_ENT = 12'h320, A_START = 12'h380,
                            A_LIVE = 12'h390, A_DIV = 12'h3E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int dummy;
    int exp_cyc_q[$];
    logic [7:0] exp_vec_q[$];
    string exp_req_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_countdown_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    // Shift expected from the divide word, per R5.
    function automatic int exp_shift(input logic [31:0] d);
        int idx;
        idx = {d[3], d[1:0]};
        return (idx == 7) ? 0 : idx + 1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write; returns the cycle index of the write edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d, output int e);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk); #1;
        e = cyc;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic push(input int c, input logic [7:0] v, input string req);
        exp_cyc_q.push_back(c);
        exp_vec_q.push_back(v);
        exp_req_q.push_back(req);
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_cyc_q.size() > 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (8) @(negedge clk);
    endtask

    // Single-shot run with given vector, divide word and count (R5, R7, R9).
    task automatic single_run(input logic [7:0] v, input logic [31:0] dcfg, input int n, input string req);
        int e;
        wr(A_ENT, {24'h0, v}, dummy);
        wr(A_DIV, dcfg, dummy);
        wr(A_START, n, e);
        push(e + n * (1 << exp_shift(dcfg)), v, req);
        drain();
        rd(A_LIVE, 32'h0, "R7");
    endtask

    // Monitor: every request must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && irq_pulse) begin
            checks++;
            if (exp_cyc_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected request actual cyc=%0d vec=%h expected none", cyc, irq_vector);
            end else begin
                int ec;
                logic [7:0] ev;
                string er;
                ec = exp_cyc_q.pop_front();
                ev = exp_vec_q.pop_front();
                er = exp_req_q.pop_front();
                if (ec != cyc || ev !== irq_vector) begin
                    fails++;
                    $display("FAIL %s request actual cyc=%0d vec=%h expected cyc=%0d vec=%h",
                             er, cyc, irq_vector, ec, ev);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int e, e2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        rd(A_ENT, 32'h0001_0000, "R1");
        rd(A_START, 32'h0, "R1");
        rd(A_LIVE, 32'h0, "R1");
        rd(A_DIV, 32'h0, "R1");
        check("R1", {31'h0, irq_pulse}, 32'h0);
        rd(12'h3F0, 32'h0, "R2");

        // R2: full-word readback
        wr(A_ENT, 32'hFFFF_FFFF, dummy);
        rd(A_ENT, 32'hFFFF_FFFF, "R2");
        wr(A_DIV, 32'hDEAD_BEEF, dummy);
        rd(A_DIV, 32'hDEAD_BEEF, "R2");
        wr(A_DIV, 32'h0, dummy);
        wr(A_ENT, 32'h0001_0000, dummy);

        // R6 + R3 + R4: frozen ticks, load copies, live writes ignored
        tick_en = 1'b0;
        wr(A_START, 32'd10, dummy);
        rd(A_LIVE, 32'd10, "R3");
        wr(A_LIVE, 32'd99, dummy);
        rd(A_LIVE, 32'd10, "R4");
        repeat (20) @(negedge clk);
        rd(A_LIVE, 32'd10, "R6");
        rd(A_START, 32'd10, "R3");
        wr(A_START, 32'd0, dummy);
        tick_en = 1'b1;

        // R5 divide variants, single-shot
        single_run(8'h41, 32'h0000_0000, 5, "R5 div2");
        single_run(8'h52, 32'h0000_000B, 4, "R5 div1");
        single_run(8'h63, 32'h0000_0008, 3, "R5 div32");
        single_run(8'h74, 32'h0000_000A, 2, "R5 div128");
        single_run(8'h85, 32'h0000_0003, 3, "R5 div16");

        // R3: rewrite mid-count restarts run and prescaler
        wr(A_ENT, 32'h0000_0099, dummy);
        wr(A_DIV, 32'h0, dummy);
        wr(A_START, 32'd5, e);
        wr(A_START, 32'd2, e2);
        push(e2 + 4, 8'h99, "R3 restart");
        drain();

        // R8: repeating mode, then mask (R9), then stop (R10)
        wr(A_ENT, 32'h0002_00A7, dummy);
        wr(A_DIV, 32'h0000_000B, dummy);
        wr(A_START, 32'd4, e);
        push(e + 4, 8'hA7, "R8");
        push(e + 8, 8'hA7, "R8");
        push(e + 12, 8'hA7, "R8");
        while (cyc < e + 12) @(negedge clk);
        wr(A_ENT, 32'h0003_00A7, dummy);
        repeat (20) @(negedge clk);
        check("R8", {31'h0, (exp_cyc_q.size() == 0)}, 32'h1);
        wr(A_START, 32'd0, dummy);
        repeat (10) @(negedge clk);
        rd(A_LIVE, 32'h0, "R10");

        // R9: masked single-shot still counts to zero, no request
        wr(A_ENT, 32'h0001_0033, dummy);
        wr(A_START, 32'd3, dummy);
        repeat (10) @(negedge clk);
        rd(A_LIVE, 32'h0, "R9");

        // R10: idle after single-shot, no request while waiting
        wr(A_ENT, 32'h0000_0044, dummy);
        repeat (30) @(negedge clk);
        rd(A_LIVE, 32'h0, "R10");

        if (exp_cyc_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R5 missing requests actual=%0d expected=0", exp_cyc_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule